// File: doc/BRIEF.md
# Leveled Interrupt Priority Resolver

This block gathers interrupt requests from a fixed number of peripheral sources and decides, every clock, whether the CPU should be interrupted and on behalf of which source. Each source owns a programmable 3-bit priority level. Level 0 is the most urgent and level 7 switches the source off. A request pulse from a source is latched as pending. It stays pending until that source is acknowledged.

Selection runs in two stages. Among the pending sources, the one with the numerically smallest level is kept. When several share that level, the lowest source index wins. Only after this winner is chosen is its level compared against a global mask threshold. It is accepted only if its level is strictly smaller than the mask, and only while the global enable input is 1. An accepted winner drives the CPU request line and publishes its index and level. When nothing is accepted, the request line stays low and the index and level outputs keep their previous contents.

Software programs the per-source levels and the mask through a small address/data/write-enable port. Everything resets to 7, so all sources start disabled and nothing can be accepted until the levels are programmed.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset every source level and the mask read as 7, no source is pending, `cpu_irq` is 0, `win_id` is 0 and `win_lvl` is 7.
- R2: With `wr_en` high, `wr_addr` values 0 to N_SRC-1 write the level of that source and `wr_addr` equal to N_SRC writes the mask. Any other address changes nothing. A written value is used by the selection on the edge after the write.
- R3: A source whose level is 7 is never accepted, whatever the mask is.
- R4: Among pending sources, the one with the numerically smallest level is the winner.
- R5: When pending sources tie on the smallest level, the lowest source index wins.
- R6: The winner is accepted only when its level is strictly less than the mask. For example, level 3 is accepted with a mask of 4 to 7 and refused with a mask of 0 to 3.
- R7: `cpu_irq` is raised only while `gie` equals 1.
- R8: A pulse on `irq_pulse[i]` sets source i pending, and it stays pending until `irq_ack[i]` is high at a clock edge. A pulse on a source that is already pending is absorbed. A pulse in the same cycle as an acknowledge leaves the source pending.
- R9: The outputs are registered from the latched state. A pulse sampled at edge k can appear on the outputs at edge k+1, and a change of `gie` sampled at edge k shows at edge k.
- R10: When no pending source is accepted, `cpu_irq` is 0 and `win_id` and `win_lvl` hold the values they had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: source level (0..N_SRC-1) or mask (N_SRC) |
| wr_data | input | 3 | Value to write |
| gie | input | 1 | Global interrupt enable |
| irq_pulse | input | N_SRC | Request pulses, one bit per source |
| irq_ack | input | N_SRC | Acknowledge, clears the pending bit of each set source |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| win_id | output | ID_W | Index of the last accepted source |
| win_lvl | output | 3 | Level of the last accepted source |

## Verification
The directed patterns cover three cases. Pending sets with distinct levels show that the level stage is working. Equal-level groups show that the fixed index order breaks ties. Pending sets that sit just below or just at the mask threshold separate strict from non-strict comparison. Further runs toggle the enable input, program level 7 on a pending source, and overlap pulses with acknowledges, to show the hold behaviour, the disable value and the latching rule. A long run of random pulses, acknowledges and register writes, including writes to unused addresses, is then compared on every edge against a behavioural model, so that latency slips by one cycle and stale level or mask values are caught.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_OFF = '1;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  lvl_t                    wr_data,
  output lvl_t [N_SRC-1:0]        lvl_o,
  output lvl_t                    mask_o
);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(N_SRC);

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_lvl
    logic we;
    lvl_t r_q;
    assign we = wr_en && (wr_addr == ADDR_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  r_q <= LVL_OFF;
      else if (we) r_q <= wr_data;
    end
    assign lvl_o[gi] = r_q;
  end

  logic mask_we;
  lvl_t mask_q;
  assign mask_we = wr_en && (wr_addr == MASK_ADDR);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= LVL_OFF;
    else if (mask_we) mask_q <= wr_data;
  end
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pulse_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_d, pend_q;

  always_comb begin
    pend_d = (pend_q & ~ack_i) | pulse_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 6,
  parameter int ID_W  = 3
) (
  input  logic [N_SRC-1:0] pend_i,
  input  lvl_t [N_SRC-1:0] lvl_i,
  output logic             any_o,
  output logic [ID_W-1:0]  id_o,
  output lvl_t             lvl_o
);
  always_comb begin
    any_o = 1'b0;
    id_o  = '0;
    lvl_o = LVL_OFF;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && (lvl_i[i] <= lvl_o)) begin
        any_o = 1'b1;
        id_o  = ID_W'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int ID_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  parameter int ADDR_W = $clog2(N_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LVL_W-1:0]  wr_data,
  input  logic              gie,
  input  logic [N_SRC-1:0]  irq_pulse,
  input  logic [N_SRC-1:0]  irq_ack,
  output logic              cpu_irq,
  output logic [ID_W-1:0]   win_id,
  output logic [LVL_W-1:0]  win_lvl
);
  lvl_t [N_SRC-1:0] lvl_w;
  lvl_t             mask_q;
  logic [N_SRC-1:0] pend_q;
  logic             any_w;
  logic [ID_W-1:0]  sel_id;
  lvl_t             sel_lvl;

  irq_cfg_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lvl_o(lvl_w), .mask_o(mask_q)
  );

  irq_pend_latch #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .pulse_i(irq_pulse), .ack_i(irq_ack),
    .pend_o(pend_q)
  );

  irq_select #(.N_SRC(N_SRC), .ID_W(ID_W)) u_sel (
    .pend_i(pend_q), .lvl_i(lvl_w), .any_o(any_w), .id_o(sel_id),
    .lvl_o(sel_lvl)
  );

  logic            accept;
  logic            irq_d, irq_q;
  logic [ID_W-1:0] id_d, id_q;
  lvl_t            lv_d, lv_q;

  always_comb begin
    accept = any_w && (sel_lvl < mask_q) && gie;
    irq_d  = accept;
    id_d   = accept ? sel_id  : id_q;
    lv_d   = accept ? sel_lvl : lv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      id_q  <= '0;
      lv_q  <= LVL_OFF;
    end else begin
      irq_q <= irq_d;
      id_q  <= id_d;
      lv_q  <= lv_d;
    end
  end

  assign cpu_irq = irq_q;
  assign win_id  = id_q;
  assign win_lvl = lv_q;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 6,
  parameter int ID_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic             cpu_irq,
  input logic [ID_W-1:0]  win_id,
  input lvl_t             win_lvl,
  input lvl_t             mask_q,
  input logic [N_SRC-1:0] pend_q
);
  a_r6_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (win_lvl < $past(mask_q)));

  a_r7_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(gie));

  a_r3_never_level7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (win_lvl != LVL_OFF));

  a_r8_winner_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ((($past(pend_q) >> win_id) & N_SRC'(1)) != '0));

  a_r10_hold_id: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq |-> ($stable(win_id) && $stable(win_lvl)));
endmodule

bind irq_level_arbiter irq_arb_chk #(.N_SRC(N_SRC), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .cpu_irq(cpu_irq),
  .win_id(win_id), .win_lvl(win_lvl), .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/tb_irq_level_arbiter.sv
`timescale 1ns/1ps
module tb_irq_level_arbiter;
  localparam int N = 6;
  localparam int IW = 3;
  localparam int AW = 3;

  logic clk, rst_n, wr_en, gie;
  logic [AW-1:0] wr_addr;
  logic [2:0] wr_data;
  logic [N-1:0] irq_pulse, irq_ack;
  logic cpu_irq;
  logic [IW-1:0] win_id;
  logic [2:0] win_lvl;

  irq_level_arbiter #(.N_SRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gie(gie), .irq_pulse(irq_pulse), .irq_ack(irq_ack),
    .cpu_irq(cpu_irq), .win_id(win_id), .win_lvl(win_lvl)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errs = 0, checks = 0;
  bit done = 0;
  bit cmp_on = 0;
  string tag = "R1";

  // behavioural reference model
  int m_lvl[N];
  int m_mask;
  bit m_pend[N];
  bit e_irq;
  int e_id, e_lvl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_lvl[i] = 7; m_pend[i] = 0; end
      m_mask = 7; e_irq = 0; e_id = 0; e_lvl = 7;
    end else begin
      int bl, bi;
      bl = 8; bi = -1;
      for (int i = 0; i < N; i++)
        if (m_pend[i] && m_lvl[i] < bl) begin bl = m_lvl[i]; bi = i; end
      if (bi >= 0 && bl < m_mask && gie) begin
        e_irq = 1; e_id = bi; e_lvl = bl;
      end else e_irq = 0;
      if (wr_en) begin
        if (wr_addr < N) m_lvl[wr_addr] = wr_data;
        else if (wr_addr == N) m_mask = wr_data;
      end
      for (int i = 0; i < N; i++)
        m_pend[i] = (m_pend[i] && !irq_ack[i]) || irq_pulse[i];
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && rst_n) begin
    chk(tag, "cpu_irq", int'(cpu_irq), int'(e_irq));
    chk(tag, "win_id", int'(win_id), e_id);
    chk(tag, "win_lvl", int'(win_lvl), e_lvl);
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 0; irq_pulse = '0; irq_ack = '0;
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    irq_pulse = '0; irq_ack = '0;
    wr_en = 1; wr_addr = AW'(a); wr_data = 3'(d);
  endtask

  task automatic pa(logic [N-1:0] p, logic [N-1:0] a);
    @(negedge clk);
    wr_en = 0; irq_pulse = p; irq_ack = a;
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; gie = 1;
    irq_pulse = '0; irq_ack = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "reset cpu_irq", int'(cpu_irq), 0);
    chk("R1", "reset win_id", int'(win_id), 0);
    chk("R1", "reset win_lvl", int'(win_lvl), 7);
    @(negedge clk); rst_n = 1;
    cmp_on = 1;
    tag = "R1"; idle(3);
    // all sources disabled at reset
    tag = "R3"; pa(6'b000100, '0); idle(3);
    chk("R3", "level7 refused", int'(cpu_irq), 0);
    pa('0, '1); idle(2);
    // program levels; write to unused address
    tag = "R2";
    wr(0, 5); wr(1, 3); wr(2, 3); wr(3, 4); wr(4, 1); wr(5, 3); wr(7, 0);
    idle(2);
    tag = "R4"; pa(6'b001011, '0); idle(3);
    chk("R4", "smallest level id", int'(win_id), 1);
    tag = "R5"; pa(6'b100100, 6'b000010); idle(3);
    chk("R5", "tie lowest index", int'(win_id), 2);
    tag = "R6"; wr(6, 3); idle(3);
    chk("R6", "mask equal refused", int'(cpu_irq), 0);
    wr(6, 4); idle(3);
    chk("R6", "mask above accepted", int'(cpu_irq), 1);
    tag = "R7"; @(negedge clk); gie = 0; idle(3);
    chk("R7", "gie low", int'(cpu_irq), 0);
    tag = "R10";
    chk("R10", "id held", int'(win_id), 2);
    @(negedge clk); gie = 1; idle(2);
    tag = "R8"; pa(6'b000100, '0); pa(6'b000100, 6'b000100); idle(3);
    chk("R8", "pulse with ack keeps pending", int'(win_id), 2);
    pa('0, 6'b000100); idle(3);
    chk("R8", "ack clears", int'(win_id), 5);
    tag = "R3"; wr(4, 7); pa(6'b010000, '0); wr(6, 7); idle(3);
    chk("R3", "level7 source loses", int'(win_id), 5);
    pa('0, '1); idle(3);
    tag = "R9";
    pa(6'b000001, '0);
    @(posedge clk); #1;
    chk("R9", "no output same edge", int'(cpu_irq), 0);
    @(posedge clk); #1;
    chk("R9", "output next edge", int'(cpu_irq), 1);
    idle(2);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      wr_en = ($urandom % 6) == 0;
      wr_addr = AW'($urandom % 8);
      wr_data = 3'($urandom % 8);
      irq_pulse = N'($urandom) & N'($urandom);
      irq_ack = N'($urandom) & N'($urandom);
      if (($urandom % 16) == 0) gie = ~gie;
    end
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule